// File: doc/BRIEF.md
# Fused multiply-add NaN result selector

This block picks the NaN result of a fused multiply-add (A*B)+C once the operands are known. It takes the three binary32 operands, a flag that says the product is an infinity-times-zero pair, a 3-bit architectural mode and a first-NaN control. It classifies each operand as non-NaN, quiet NaN or signaling NaN and applies the selection order of the chosen mode. It returns a 2-bit select code, an invalid strobe and the final 32-bit result. A signaling operand that is picked comes out quieted.

The outputs are registered: a request accepted on one rising edge shows its result on the outputs after that edge. The result is marked valid only when the datapath needs it, which means some operand is a NaN or the infinity-times-zero flag is set. In every other cycle all outputs read zero.

Top module: `fma_nan_select`

## Requirements
- R1: Outputs are registered one clock after the request. `out_valid` is 1 only when `in_valid` was 1 and either some operand is a NaN or `inf_zero` was set. When `out_valid` is 0, `out_sel`, `out_invalid` and `out_result` are all 0. Select codes are 0=A, 1=B, 2=C and 3=default NaN.
- R2: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are non-zero. In every mode except mode 2, bit 22 = 1 means quiet and bit 22 = 0 means signaling. Mode 2 uses the opposite polarity: bit 22 = 1 means signaling.
- R3: Mode 1 (addend first). If `inf_zero` is set and C is quiet, the code is 3 and invalid is raised. Otherwise the order is signaling C, signaling A, signaling B, quiet C, quiet A, and B if none of these applies.
- R4: Mode 2 (legacy polarity). If `inf_zero` is set, the code is 3 and invalid is raised. Otherwise the order is signaling A, signaling B, signaling C, quiet A, quiet B, and C if none of these applies.
- R5: Mode 3 (revised polarity). If `inf_zero` is set, the code is 2 and invalid is raised. Otherwise the order is signaling C, signaling A, signaling B, quiet C, quiet A, and B if none of these applies.
- R6: Mode 4 (addend preferring). If `inf_zero` is set, the code is 2 and invalid is raised. Otherwise the block takes A if A is any NaN, then C if C is any NaN, and B otherwise.
- R7: Mode 5 (switchable). If `inf_zero` is set, the code is 2 and invalid is raised. Otherwise, with `first_nan`=1 it takes the first NaN in the order A, B, C. With `first_nan`=0 it takes the first NaN in the order C, B, A. If no operand is a NaN it takes the last operand of that order.
- R8: Modes 0, 6 and 7 (fallback) take A if A is a NaN, then B if B is a NaN, and C otherwise. In these modes `inf_zero` does not raise invalid.
- R9: `out_invalid` is raised whenever any operand is a signaling NaN, whichever operand is selected, and also when a mode's infinity-times-zero rule fires.
- R10: For code 3 the result is the default NaN: 0x7FC00000, or 0x7FBFFFFF in mode 2. A selected signaling operand is quieted: bit 22 is set, except in mode 2, where the default NaN is returned instead. Any other selected operand passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Architectural selection mode |
| first_nan | input | 1 | Order control for mode 5 |
| inf_zero | input | 1 | A*B is an infinity-times-zero pair |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| op_c | input | 32 | Operand C (addend), binary32 |
| out_valid | output | 1 | NaN result present |
| out_sel | output | 2 | Select code |
| out_invalid | output | 1 | Invalid-operation strobe |
| out_result | output | 32 | Selected, quieted result |

## Verification
Two functions can fall in the same cycle: the infinity-times-zero rule, and the raising of invalid by a signaling operand. The bench provokes both together in two ways. In mode 3 it sets `inf_zero` while A is signaling. In mode 1 it sets `inf_zero` while C is signaling rather than quiet. It expects code 2 with invalid raised in both cases, and a quieted C in the mode 1 case. A second pairing is selection combined with quieting: in mode 2, a selected signaling operand must turn into the mode's default NaN in the same cycle that its code is reported.

// File: rtl/fma_nan_select.sv
module fma_nan_select (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  mode,
  input  logic        first_nan,
  input  logic        inf_zero,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [31:0] op_c,
  output logic        out_valid,
  output logic [1:0]  out_sel,
  output logic        out_invalid,
  output logic [31:0] out_result
);

  localparam logic [31:0] DNAN_STD = 32'h7FC0_0000;
  localparam logic [31:0] DNAN_LEG = 32'h7FBF_FFFF;

  logic        leg;
  logic        na, nb, nc, sa, sb, sc, qa, qb, qc;
  logic [1:0]  sel;
  logic        rule_inv;
  logic [31:0] picked, res, dnan;
  logic        pick_sig, take;

  assign leg = (mode == 3'd2);
  assign na  = (&op_a[30:23]) && (|op_a[22:0]);
  assign nb  = (&op_b[30:23]) && (|op_b[22:0]);
  assign nc  = (&op_c[30:23]) && (|op_c[22:0]);
  assign sa  = na && (op_a[22] == leg);
  assign sb  = nb && (op_b[22] == leg);
  assign sc  = nc && (op_c[22] == leg);
  assign qa  = na && !sa;
  assign qb  = nb && !sb;
  assign qc  = nc && !sc;

  always_comb begin
    sel      = 2'd0;
    rule_inv = 1'b0;
    case (mode)
      3'd1: begin
        if (inf_zero && qc) begin sel = 2'd3; rule_inv = 1'b1; end
        else if (sc) sel = 2'd2;
        else if (sa) sel = 2'd0;
        else if (sb) sel = 2'd1;
        else if (qc) sel = 2'd2;
        else if (qa) sel = 2'd0;
        else         sel = 2'd1;
      end
      3'd2: begin
        if (inf_zero) begin sel = 2'd3; rule_inv = 1'b1; end
        else if (sa) sel = 2'd0;
        else if (sb) sel = 2'd1;
        else if (sc) sel = 2'd2;
        else if (qa) sel = 2'd0;
        else if (qb) sel = 2'd1;
        else         sel = 2'd2;
      end
      3'd3: begin
        if (inf_zero) begin sel = 2'd2; rule_inv = 1'b1; end
        else if (sc) sel = 2'd2;
        else if (sa) sel = 2'd0;
        else if (sb) sel = 2'd1;
        else if (qc) sel = 2'd2;
        else if (qa) sel = 2'd0;
        else         sel = 2'd1;
      end
      3'd4: begin
        if (inf_zero) begin sel = 2'd2; rule_inv = 1'b1; end
        else if (na) sel = 2'd0;
        else if (nc) sel = 2'd2;
        else         sel = 2'd1;
      end
      3'd5: begin
        if (inf_zero) begin sel = 2'd2; rule_inv = 1'b1; end
        else if (first_nan) sel = na ? 2'd0 : (nb ? 2'd1 : 2'd2);
        else                sel = nc ? 2'd2 : (nb ? 2'd1 : 2'd0);
      end
      default: sel = na ? 2'd0 : (nb ? 2'd1 : 2'd2);
    endcase
  end

  always_comb begin
    case (sel)
      2'd0:    begin picked = op_a; pick_sig = sa; end
      2'd1:    begin picked = op_b; pick_sig = sb; end
      default: begin picked = op_c; pick_sig = sc; end
    endcase
  end

  assign dnan = leg ? DNAN_LEG : DNAN_STD;
  assign res  = (sel == 2'd3) ? dnan
              : pick_sig ? (leg ? dnan : (picked | 32'h0040_0000))
              : picked;
  assign take = in_valid && (na || nb || nc || inf_zero);

  always_ff @(posedge clk) begin
    if (!rst_n || !take) begin
      out_valid   <= 1'b0;
      out_sel     <= 2'd0;
      out_invalid <= 1'b0;
      out_result  <= 32'd0;
    end else begin
      out_valid   <= 1'b1;
      out_sel     <= sel;
      out_invalid <= rule_inv || sa || sb || sc;
      out_result  <= res;
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_sel == 2'd0 && !out_invalid && out_result == 32'd0));

  a_r1_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r3_default_code_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel == 2'd3) |-> ($past(mode) == 3'd1 || $past(mode) == 3'd2));

  a_r4_legacy_infzero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 3'd2 && $past(inf_zero)) |-> (out_sel == 2'd3 && out_invalid));

  a_r10_nan_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(inf_zero)) |-> (&out_result[30:23] && |out_result[22:0]));

  a_r10_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(inf_zero) && $past(mode) != 3'd2) |-> out_result[22]);

  a_r5_infzero_c: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(inf_zero) && $past(mode) >= 3'd3 && $past(mode) <= 3'd5)
      |-> (out_sel == 2'd2 && out_invalid));

endmodule

// File: tb/fma_nan_select_tb.sv
`timescale 1ns/1ps
module fma_nan_select_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] mode = 3'd0;
  logic first_nan = 1'b0;
  logic inf_zero = 1'b0;
  logic [31:0] op_a = 32'd0, op_b = 32'd0, op_c = 32'd0;
  logic out_valid, out_invalid;
  logic [1:0] out_sel;
  logic [31:0] out_result;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  fma_nan_select u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .first_nan(first_nan), .inf_zero(inf_zero), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .out_valid(out_valid), .out_sel(out_sel),
    .out_invalid(out_invalid), .out_result(out_result));

  localparam logic [31:0] NV = 32'h3F80_0000;
  localparam logic [31:0] QA = 32'h7FC0_000A, QB = 32'h7FC0_000B, QC = 32'h7FC0_000C;
  localparam logic [31:0] SA = 32'h7F80_000A, SB = 32'h7F80_000B, SC = 32'h7F80_000C;
  localparam logic [31:0] DS = 32'h7FC0_0000, DL = 32'h7FBF_FFFF;

  localparam int NV_CNT = 25;
  localparam logic [136:0] VEC [NV_CNT] = '{
    {3'd0,1'b0,1'b0, NV,QB,QC, 2'd1,1'b0,1'b1, QB},
    {3'd0,1'b0,1'b0, SA,QB,NV, 2'd0,1'b1,1'b1, QA},
    {3'd0,1'b0,1'b0, NV,NV,NV, 2'd0,1'b0,1'b0, 32'd0},
    {3'd1,1'b0,1'b1, NV,NV,QC, 2'd3,1'b1,1'b1, DS},
    {3'd1,1'b0,1'b0, SA,SB,QC, 2'd0,1'b1,1'b1, QA},
    {3'd1,1'b0,1'b0, QA,SB,QC, 2'd1,1'b1,1'b1, QB},
    {3'd1,1'b0,1'b0, QA,QB,QC, 2'd2,1'b0,1'b1, QC},
    {3'd1,1'b0,1'b0, NV,QB,NV, 2'd1,1'b0,1'b1, QB},
    {3'd2,1'b0,1'b0, QA,NV,SC, 2'd0,1'b1,1'b1, DL},
    {3'd2,1'b0,1'b0, SA,SB,QC, 2'd2,1'b1,1'b1, DL},
    {3'd2,1'b0,1'b0, NV,SB,SC, 2'd1,1'b0,1'b1, SB},
    {3'd2,1'b0,1'b1, NV,NV,NV, 2'd3,1'b1,1'b1, DL},
    {3'd3,1'b0,1'b1, SA,NV,QC, 2'd2,1'b1,1'b1, QC},
    {3'd3,1'b0,1'b0, QA,SB,QC, 2'd1,1'b1,1'b1, QB},
    {3'd3,1'b0,1'b1, NV,NV,NV, 2'd2,1'b1,1'b1, NV},
    {3'd4,1'b0,1'b0, NV,QB,QC, 2'd2,1'b0,1'b1, QC},
    {3'd4,1'b0,1'b0, QA,SB,QC, 2'd0,1'b1,1'b1, QA},
    {3'd4,1'b0,1'b1, QA,NV,NV, 2'd2,1'b1,1'b1, NV},
    {3'd5,1'b1,1'b0, NV,QB,QC, 2'd1,1'b0,1'b1, QB},
    {3'd5,1'b0,1'b0, QA,QB,NV, 2'd1,1'b0,1'b1, QB},
    {3'd5,1'b0,1'b0, QA,NV,SC, 2'd2,1'b1,1'b1, QC},
    {3'd5,1'b1,1'b1, QA,NV,QC, 2'd2,1'b1,1'b1, QC},
    {3'd1,1'b0,1'b1, NV,NV,SC, 2'd2,1'b1,1'b1, QC},
    {3'd7,1'b0,1'b0, NV,NV,SC, 2'd2,1'b1,1'b1, QC},
    {3'd0,1'b0,1'b1, NV,NV,NV, 2'd2,1'b0,1'b1, NV}
  };

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] m, input logic f, input logic iz,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    in_valid = v; mode = m; first_nan = f; inf_zero = iz;
    op_a = a; op_b = b; op_c = c;
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset result", out_result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV_CNT; i++) begin
      logic [136:0] v;
      v = VEC[i];
      drive(1'b1, v[136:134], v[133], v[132], v[131:100], v[99:68], v[67:36]);
      @(negedge clk);
      check({mode_req(v[136:134]), " sel"}, {30'd0, out_sel}, {30'd0, v[35:34]});
      check("R9 invalid", {31'd0, out_invalid}, {31'd0, v[33]});
      check("R1 valid", {31'd0, out_valid}, {31'd0, v[32]});
      check("R10 result", out_result, v[31:0]);
    end

    // R1: request without in_valid is ignored
    drive(1'b0, 3'd2, 1'b0, 1'b1, SA, SB, SC);
    @(negedge clk);
    check("R1 idle valid", {31'd0, out_valid}, 32'd0);
    check("R1 idle invalid", {31'd0, out_invalid}, 32'd0);
    check("R1 idle result", out_result, 32'd0);

    // R2: inverted polarity in mode 2 versus normal polarity in mode 0 on the same operand
    drive(1'b1, 3'd0, 1'b0, 1'b0, QA, NV, NV);
    @(negedge clk);
    check("R2 normal quiet", {31'd0, out_invalid}, 32'd0);
    drive(1'b1, 3'd2, 1'b0, 1'b0, QA, NV, NV);
    @(negedge clk);
    check("R2 legacy signaling", {31'd0, out_invalid}, 32'd1);
    // R2: infinity is not a NaN
    drive(1'b1, 3'd0, 1'b0, 1'b0, 32'h7F80_0000, NV, NV);
    @(negedge clk);
    check("R2 infinity", {31'd0, out_valid}, 32'd0);

    // R1: back-to-back requests, then reset clears
    drive(1'b1, 3'd4, 1'b0, 1'b0, NV, NV, QC);
    @(negedge clk);
    check("R6 b2b first", out_result, QC);
    drive(1'b1, 3'd4, 1'b0, 1'b0, NV, QB, NV);
    @(negedge clk);
    check("R6 b2b second", out_result, QB);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    drive(1'b0, 3'd0, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule